// File: doc/BRIEF.md
# Bipolar Return-to-Zero Serial Word Receiver

This block turns a bipolar return-to-zero serial stream into data words. The stream arrives as two sampled logic lines from a line comparator. A pulse on the first line carries a one. A pulse on the second line carries a zero. Every pulse is followed by a null, during which both lines are low. A long null separates one word from the next. The block samples both lines on every edge of a 1 MHz clock. Pulses shorter than a minimum width are treated as noise. A pulse on which both lines are high is treated as corrupt. Pulses are collected into a word of 32 or 25 bits. At the closing gap, the word is delivered or dropped.

Configuration inputs set the following:
- the line rate: a high rate near 100 kbps or a low rate near 12.5 kbps;
- the word length;
- whether odd parity is checked;
- whether two source/destination bits of the word must match two programmed values.

An active-low self-test input switches the receiver from the external lines to a loopback pair driven by a local transmitter. A delivered word is presented with a one-cycle valid strobe and a parity-error flag.

Top module: `bprz_word_rx`

## Requirements
- R1: While reset is held, and right after it is released, `rx_valid`, `rx_par_err` and `rx_word` are all zero.
- R2: A pulse of at least the minimum width on line A is received as a one. A pulse of at least that width on line B is received as a zero. The first bit received after a gap is placed at `rx_word[0]`, the next at `rx_word[1]`, and so on.
- R3: With `cfg_len25`=0 a word is 32 bits. With `cfg_len25`=1 a word is 25 bits, and `rx_word[31:25]` is delivered as zero.
- R4: `cfg_rate_lo`=1 selects the low-rate timing: minimum pulse 24 samples and gap 240 samples. `cfg_rate_lo`=0 selects the high-rate timing: minimum pulse 3 samples and gap 30 samples. High-rate pulses (4 to 6 samples) received in low-rate mode yield no word.
- R5: The parity check uses odd parity over all received bits of the word. With `cfg_par_en`=1, a word with an even number of ones is delivered with `rx_par_err`=1. With `cfg_par_en`=0, `rx_par_err` stays 0. `rx_par_err` is never high without `rx_valid`.
- R6: With `cfg_sdi_en`=1, a word is dropped unless `rx_word[8]` equals `cfg_sdi_x` and `rx_word[9]` equals `cfg_sdi_y`. With `cfg_sdi_en`=0, these two bits are not filtered.
- R7: A null lasting at least the gap length ends the word. A word is delivered only at such a gap, and only if exactly the configured number of bits was received. Words that are short or too long are dropped.
- R8: If any pulse within a word has both lines high at the same time, that word is dropped.
- R9: A pulse shorter than the minimum width is ignored. It neither adds a bit nor ends the word.
- R10: With `cfg_stest_n`=0 the receiver listens only to `loop_a`/`loop_b`. With `cfg_stest_n`=1 it listens only to `line_a`/`line_b`.
- R11: Each delivered word raises `rx_valid` for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rate_lo | input | 1 | 1 = low rate, 0 = high rate |
| cfg_len25 | input | 1 | 1 = 25-bit words, 0 = 32-bit words |
| cfg_par_en | input | 1 | Enable the odd parity check |
| cfg_sdi_en | input | 1 | Enable the source/destination bit filter |
| cfg_sdi_x | input | 1 | Required value of word bit 8 |
| cfg_sdi_y | input | 1 | Required value of word bit 9 |
| cfg_stest_n | input | 1 | 0 = take input from the loopback pair |
| line_a | input | 1 | External line, pulse means one |
| line_b | input | 1 | External line, pulse means zero |
| loop_a | input | 1 | Loopback line, pulse means one |
| loop_b | input | 1 | Loopback line, pulse means zero |
| rx_word | output | 32 | Last delivered word |
| rx_valid | output | 1 | One-cycle strobe for a delivered word |
| rx_par_err | output | 1 | Parity mismatch on the delivered word |

## Verification
Random words are sent at both rates, with randomly varied pulse and null widths and random settings for word length, parity and source/destination filtering. These runs show whether bit order, masking, the filter decision and the parity flag all agree with an independent model. Directed streams then cover the edge cases:
- words one bit short and one bit long, which separate exact-count delivery from partial or overrun words;
- a collision pulse and a sub-minimum glitch, which show the difference between a corrupt pulse and ignored noise;
- high-rate pulses sent in low-rate mode, which expose the rate thresholds;
- traffic on the unselected line pair in each self-test setting, which shows that the input source is switched cleanly.

// File: rtl/bprz_rx_pkg.sv
package bprz_rx_pkg;

   localparam int WORD_W = 32;

   // Events produced by the pulse classifier for the word assembler.
   typedef struct packed {
      logic bit_stb;   // a valid data pulse has ended
      logic bit_val;   // its value (1 = line A)
      logic coll_stb;  // a pulse had both lines high
      logic gap_stb;   // the inter-word null has reached its length
   } rx_evt_t;

endpackage

// File: rtl/bprz_rx_insel.sv
module bprz_rx_insel #(
   parameter int SYNC_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stest_n,
   input  logic line_a,
   input  logic line_b,
   input  logic loop_a,
   input  logic loop_b,
   output logic smp_a,
   output logic smp_b
);

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("bprz_rx_insel: SYNC_STAGES must be 1 to 4");
      end
   endgenerate

   logic [1:0] sel_d;
   logic [SYNC_STAGES-1:0][1:0] stg;

   assign sel_d = stest_n ? {line_a, line_b} : {loop_a, loop_b};

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg[0] <= sel_d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[SYNC_STAGES-2:0], sel_d};
         end
      end
   endgenerate

   assign smp_a = stg[SYNC_STAGES-1][1];
   assign smp_b = stg[SYNC_STAGES-1][0];

endmodule

// File: rtl/bprz_rx_pulse.sv
module bprz_rx_pulse
   import bprz_rx_pkg::*;
#(
   parameter int MIN_HS = 3,
   parameter int MIN_LS = 24,
   parameter int GAP_HS = 30,
   parameter int GAP_LS = 240
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    rate_lo,
   input  logic    smp_a,
   input  logic    smp_b,
   output rx_evt_t evt
);

   localparam int HCW = $clog2(MIN_LS + 1);
   localparam int NCW = $clog2(GAP_LS + 1);

   generate
      if (MIN_HS < 1 || MIN_LS < MIN_HS) begin : g_bad_min
         $error("bprz_rx_pulse: need 1 <= MIN_HS <= MIN_LS");
      end
      if (GAP_HS < 2 || GAP_LS < GAP_HS) begin : g_bad_gap
         $error("bprz_rx_pulse: need 2 <= GAP_HS <= GAP_LS");
      end
   endgenerate

   logic           act;
   logic           act_q;
   logic [HCW-1:0] hi_cnt;
   logic           seen_a;
   logic           coll_seen;
   logic [NCW-1:0] null_cnt;
   logic [HCW-1:0] min_sel;
   logic [NCW-1:0] gap_last;

   assign act      = smp_a | smp_b;
   assign min_sel  = rate_lo ? HCW'(MIN_LS) : HCW'(MIN_HS);
   assign gap_last = rate_lo ? NCW'(GAP_LS - 1) : NCW'(GAP_HS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         hi_cnt    <= '0;
         seen_a    <= 1'b0;
         coll_seen <= 1'b0;
         null_cnt  <= NCW'(GAP_LS);
         evt       <= '0;
      end else begin
         act_q <= act;
         evt   <= '0;
         // pulse width measurement, judged when the pulse ends
         if (act) begin
            if (hi_cnt != HCW'(MIN_LS)) hi_cnt <= hi_cnt + 1'b1;
            seen_a    <= seen_a | smp_a;
            coll_seen <= coll_seen | (smp_a & smp_b);
         end else if (act_q) begin
            if (coll_seen) begin
               evt.coll_stb <= 1'b1;
            end else if (hi_cnt >= min_sel) begin
               evt.bit_stb <= 1'b1;
               evt.bit_val <= seen_a;
            end
            hi_cnt    <= '0;
            seen_a    <= 1'b0;
            coll_seen <= 1'b0;
         end
         // null run length, saturating so the gap fires once per run
         if (act) begin
            null_cnt <= '0;
         end else if (null_cnt != NCW'(GAP_LS)) begin
            null_cnt <= null_cnt + 1'b1;
         end
         if (!act && null_cnt == gap_last) evt.gap_stb <= 1'b1;
      end
   end

   // a bit is reported only after a high sample followed by a low sample
   assert_bit_after_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt.bit_stb |-> ($past(!act) && $past(act, 2)));

   // a gap is reported only while the lines are idle
   assert_gap_on_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt.gap_stb |-> $past(!act));

endmodule

// File: rtl/bprz_rx_word.sv
module bprz_rx_word
   import bprz_rx_pkg::*;
#(
   parameter int W         = WORD_W,
   parameter int SHORT_LEN = 25,
   parameter int SDI_POS   = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  rx_evt_t      evt,
   input  logic         len_short,
   input  logic         par_en,
   input  logic         sdi_en,
   input  logic         sdi_x,
   input  logic         sdi_y,
   output logic [W-1:0] rx_word,
   output logic         rx_valid,
   output logic         rx_par_err
);

   localparam int CW = $clog2(W + 1);
   localparam int IW = $clog2(W);

   generate
      if (SHORT_LEN < 1 || SHORT_LEN >= W) begin : g_bad_len
         $error("bprz_rx_word: SHORT_LEN must be below W");
      end
      if (SDI_POS + 1 >= SHORT_LEN) begin : g_bad_sdi
         $error("bprz_rx_word: SDI bits must lie inside the short word");
      end
   endgenerate

   logic [W-1:0]  shreg;
   logic [CW-1:0] cnt;
   logic          par;
   logic          err;
   logic [CW-1:0] len;
   logic          sdi_ok;
   logic          deliver;

   assign len     = len_short ? CW'(SHORT_LEN) : CW'(W);
   assign sdi_ok  = !sdi_en || (shreg[SDI_POS] == sdi_x && shreg[SDI_POS+1] == sdi_y);
   assign deliver = (cnt == len) && !err && sdi_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         cnt        <= '0;
         par        <= 1'b0;
         err        <= 1'b0;
         rx_word    <= '0;
         rx_valid   <= 1'b0;
         rx_par_err <= 1'b0;
      end else begin
         rx_valid   <= 1'b0;
         rx_par_err <= 1'b0;
         if (evt.gap_stb) begin
            if (deliver) begin
               rx_valid   <= 1'b1;
               rx_word    <= shreg;
               rx_par_err <= par_en && !par;
            end
            shreg <= '0;
            cnt   <= '0;
            par   <= 1'b0;
            err   <= 1'b0;
         end else begin
            if (evt.coll_stb) err <= 1'b1;
            if (evt.bit_stb) begin
               if (cnt < len) begin
                  shreg[cnt[IW-1:0]] <= evt.bit_val;
                  cnt <= cnt + 1'b1;
                  par <= par ^ evt.bit_val;
               end else begin
                  err <= 1'b1;
               end
            end
         end
      end
   end

   assert_valid_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_perr_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> !rx_par_err);

   assert_perr_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_par_err |-> $past(par_en));

   assert_short_word_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (!$past(len_short) || rx_word[W-1:SHORT_LEN] == '0));

   assert_sdi_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (!$past(sdi_en) ||
                    (rx_word[SDI_POS] == $past(sdi_x) && rx_word[SDI_POS+1] == $past(sdi_y))));

   assert_deliver_at_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(evt.gap_stb));

   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(W));

endmodule

// File: rtl/bprz_word_rx.sv
module bprz_word_rx
   import bprz_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 1,
   parameter int MIN_HS      = 3,
   parameter int MIN_LS      = 24,
   parameter int GAP_HS      = 30,
   parameter int GAP_LS      = 240,
   parameter int SHORT_LEN   = 25,
   parameter int SDI_POS     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_rate_lo,
   input  logic              cfg_len25,
   input  logic              cfg_par_en,
   input  logic              cfg_sdi_en,
   input  logic              cfg_sdi_x,
   input  logic              cfg_sdi_y,
   input  logic              cfg_stest_n,
   input  logic              line_a,
   input  logic              line_b,
   input  logic              loop_a,
   input  logic              loop_b,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              rx_par_err
);

   logic    smp_a;
   logic    smp_b;
   rx_evt_t evt;

   bprz_rx_insel #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_insel (
      .clk     (clk),
      .rst_n   (rst_n),
      .stest_n (cfg_stest_n),
      .line_a  (line_a),
      .line_b  (line_b),
      .loop_a  (loop_a),
      .loop_b  (loop_b),
      .smp_a   (smp_a),
      .smp_b   (smp_b)
   );

   bprz_rx_pulse #(
      .MIN_HS (MIN_HS),
      .MIN_LS (MIN_LS),
      .GAP_HS (GAP_HS),
      .GAP_LS (GAP_LS)
   ) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .rate_lo (cfg_rate_lo),
      .smp_a   (smp_a),
      .smp_b   (smp_b),
      .evt     (evt)
   );

   bprz_rx_word #(
      .W         (WORD_W),
      .SHORT_LEN (SHORT_LEN),
      .SDI_POS   (SDI_POS)
   ) u_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .len_short  (cfg_len25),
      .par_en     (cfg_par_en),
      .sdi_en     (cfg_sdi_en),
      .sdi_x      (cfg_sdi_x),
      .sdi_y      (cfg_sdi_y),
      .rx_word    (rx_word),
      .rx_valid   (rx_valid),
      .rx_par_err (rx_par_err)
   );

endmodule

// File: tb/bprz_word_rx_bench.sv
module bprz_word_rx_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_rate_lo = 1'b0;
   logic        cfg_len25 = 1'b0;
   logic        cfg_par_en = 1'b0;
   logic        cfg_sdi_en = 1'b0;
   logic        cfg_sdi_x = 1'b0;
   logic        cfg_sdi_y = 1'b0;
   logic        cfg_stest_n = 1'b1;
   logic        line_a = 1'b0;
   logic        line_b = 1'b0;
   logic        loop_a = 1'b0;
   logic        loop_b = 1'b0;
   logic [31:0] rx_word;
   logic        rx_valid;
   logic        rx_par_err;

   int          n_checks = 0;
   int          n_fail = 0;
   int          vcount = 0;
   logic [31:0] cap_word = '0;
   logic        cap_perr = 1'b0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   bprz_word_rx u_bprz_word_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_rate_lo (cfg_rate_lo),
      .cfg_len25   (cfg_len25),
      .cfg_par_en  (cfg_par_en),
      .cfg_sdi_en  (cfg_sdi_en),
      .cfg_sdi_x   (cfg_sdi_x),
      .cfg_sdi_y   (cfg_sdi_y),
      .cfg_stest_n (cfg_stest_n),
      .line_a      (line_a),
      .line_b      (line_b),
      .loop_a      (loop_a),
      .loop_b      (loop_b),
      .rx_word     (rx_word),
      .rx_valid    (rx_valid),
      .rx_par_err  (rx_par_err)
   );

   // capture delivered words away from the active edge
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         vcount   = vcount + 1;
         cap_word = rx_word;
         cap_perr = rx_par_err;
      end
   end

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   function automatic logic [31:0] exp_mask(logic [31:0] w, bit len25);
      return len25 ? (w & 32'h01FF_FFFF) : w;
   endfunction

   function automatic bit exp_deliver(logic [31:0] w, bit sdi_en, bit x, bit y);
      return !sdi_en || (w[8] == x && w[9] == y);
   endfunction

   function automatic bit exp_perr(logic [31:0] w, bit par_en);
      return par_en && ($countones(w) % 2 == 0);
   endfunction

   // hold a line pair for n cycles; entered and left at a falling edge
   task automatic drive(bit a, bit b, bit lp, int n);
      if (lp) begin
         loop_a = a; loop_b = b;
      end else begin
         line_a = a; line_b = b;
      end
      repeat (n) @(negedge clk);
   endtask

   task automatic send_word(logic [31:0] w, int nbits, bit ls, bit hs_timing_in_ls,
                            bit lp, int coll_at, bit glitch);
      for (int i = 0; i < nbits; i++) begin
         int hi;
         int lo;
         if (ls && !hs_timing_in_ls) begin
            hi = 30 + int'($urandom % 21);
            lo = 30 + int'($urandom % 21);
         end else begin
            hi = 4 + int'($urandom % 3);
            lo = 4 + int'($urandom % 3);
         end
         if (i == coll_at) drive(1'b1, 1'b1, lp, hi);
         else              drive(w[i], !w[i], lp, hi);
         drive(1'b0, 1'b0, lp, lo);
         if (glitch && i == nbits / 2) begin
            drive(1'b1, 1'b0, lp, 2);
            drive(1'b0, 1'b0, lp, lo);
         end
      end
      drive(1'b0, 1'b0, lp, ls ? 300 : 45);
   endtask

   // send one word and compare the outcome with the model
   task automatic run_word(string req, logic [31:0] w, int nbits, bit lp,
                           bit must_drop, int coll_at, bit glitch);
      int          v0;
      logic [31:0] ew;
      bit          del;
      v0  = vcount;
      ew  = exp_mask(w, cfg_len25);
      del = !must_drop && exp_deliver(ew, cfg_sdi_en, cfg_sdi_x, cfg_sdi_y);
      send_word(w, nbits, cfg_rate_lo, 1'b0, lp, coll_at, glitch);
      if (del) begin
         check(vcount == v0 + 1, {req, " R11 one valid"}, vcount - v0, 1);
         check(cap_word == ew, {req, " word"}, cap_word, ew);
         check(cap_perr == exp_perr(ew, cfg_par_en), {req, " R5 parity"},
               cap_perr, exp_perr(ew, cfg_par_en));
      end else begin
         check(vcount == v0, {req, " dropped"}, vcount - v0, 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      // R1: reset state
      check(rx_valid == 1'b0 && rx_par_err == 1'b0 && rx_word == '0,
            "R1 during reset", {rx_valid, rx_par_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rx_valid == 1'b0 && rx_par_err == 1'b0 && rx_word == '0,
            "R1 after reset", rx_word, 0);
      repeat (300) @(negedge clk);

      // R2 directed bit order, 32-bit word
      cfg_par_en = 1'b1;
      run_word("R2 order", 32'h8000_0001, 32, 1'b0, 1'b0, -1, 1'b0);
      run_word("R2 pattern", 32'h1234_5678, 32, 1'b0, 1'b0, -1, 1'b0);
      // R5 parity off
      cfg_par_en = 1'b0;
      run_word("R5 disabled", 32'h0000_0003, 32, 1'b0, 1'b0, -1, 1'b0);
      cfg_par_en = 1'b1;
      // R3 short words
      cfg_len25 = 1'b1;
      run_word("R3 short len", 32'hFFFF_FFFF, 25, 1'b0, 1'b0, -1, 1'b0);
      run_word("R7 short by one", 32'h0155_5555, 24, 1'b0, 1'b1, -1, 1'b0);
      run_word("R7 long by one", 32'h0155_5555, 26, 1'b0, 1'b1, -1, 1'b0);
      cfg_len25 = 1'b0;
      run_word("R7 32 short by one", 32'hA5A5_A5A5, 31, 1'b0, 1'b1, -1, 1'b0);
      run_word("R7 32 long by one", 32'hA5A5_A5A5, 33, 1'b0, 1'b1, -1, 1'b0);
      // R8 collision
      run_word("R8 collision", 32'h0F0F_0F0F, 32, 1'b0, 1'b1, 7, 1'b0);
      // R9 glitch ignored
      run_word("R9 glitch", 32'hC3C3_3C3C, 32, 1'b0, 1'b0, -1, 1'b1);
      // R6 filter match and mismatch
      cfg_sdi_en = 1'b1; cfg_sdi_x = 1'b1; cfg_sdi_y = 1'b0;
      run_word("R6 match", 32'h0000_0100, 32, 1'b0, 1'b0, -1, 1'b0);
      run_word("R6 mismatch", 32'h0000_0200, 32, 1'b0, 1'b0, -1, 1'b0);
      cfg_sdi_en = 1'b0;
      // R10 self-test source selection
      cfg_stest_n = 1'b0;
      run_word("R10 line ignored in test", 32'h1111_2222, 32, 1'b0, 1'b1, -1, 1'b0);
      run_word("R10 loop used", 32'h3333_4444, 32, 1'b1, 1'b0, -1, 1'b0);
      cfg_stest_n = 1'b1;
      run_word("R10 loop ignored", 32'h5555_6666, 32, 1'b1, 1'b1, -1, 1'b0);
      // R4 high-rate pulses in low-rate mode yield nothing
      cfg_rate_lo = 1'b1;
      begin
         int v0;
         v0 = vcount;
         send_word(32'h7777_8888, 32, 1'b1, 1'b1, 1'b0, -1, 1'b0);
         check(vcount == v0, "R4 fast pulses in slow mode", vcount - v0, 0);
      end
      // R4 low-rate words with random settings
      for (int k = 0; k < 5; k++) begin
         cfg_len25  = 1'($urandom % 2);
         cfg_par_en = 1'($urandom % 2);
         run_word("R4 slow random", $urandom, cfg_len25 ? 25 : 32, 1'b0, 1'b0, -1, 1'b0);
      end
      cfg_rate_lo = 1'b0;
      // random high-rate words, R2 R3 R5 R6
      for (int k = 0; k < 150; k++) begin
         logic [31:0] w;
         w          = $urandom;
         cfg_len25  = 1'($urandom % 2);
         cfg_par_en = 1'($urandom % 2);
         cfg_sdi_en = 1'($urandom % 3 == 0);
         cfg_sdi_x  = 1'($urandom % 2);
         cfg_sdi_y  = 1'($urandom % 2);
         run_word("R2 R6 random", w, cfg_len25 ? 25 : 32, 1'b0, 1'b0, -1, 1'b0);
      end
      finish_run();
   end

endmodule